// File: doc/BRIEF.md
# SPI Transmit Buffer Fetcher

This block sits between buffer memory and an SPI shift engine. Software describes a transmit buffer with a start address and a byte count, chooses a character width between 4 and 16 bits and a master or slave role, and then writes a one-bit start command. The block reads the buffer upward from the start address, packs the bytes into characters and hands them one at a time to the shifter over a valid/ready stream. When the last character has been taken, it raises a one-cycle done pulse.

Characters of 8 bits or fewer use one byte each. Wider characters use a 16-bit half-word each, with the byte at the lower address as the upper byte. For wide characters the byte count and the start address must both be even. A descriptor that breaks these rules, or that has a count of zero, is refused with an error pulse and causes no memory read.

The character stream follows the usual rules. `tx_data` is meaningful only while `tx_valid` is high. Once `tx_valid` is raised, it stays high and `tx_data` stays unchanged until a cycle with `tx_ready` high. A character moves in a cycle where both signals are high, and the shifter may hold `tx_ready` low for as long as it needs.

Top module: `spi_txbuf_fetch`

## Requirements
- R1: The command byte is 8 bits wide. Bit 0 is the start bit. Bits 7..1 always read as 0, and writes to them have no effect.
- R2: The start bit resets to 0. After a write with bit 0 set, it reads 1 for exactly one cycle and then reads 0 again.
- R3: In master mode (`slave_mode`=0), a start is taken only if `bd_ready` is 1. Otherwise the start is dropped: no read, no character, and nothing is kept for later.
- R4: A start that arrives during a transfer is dropped. The current transfer continues unchanged, and no second transfer follows it.
- R5: When `char_bits` is 8 or less, each character is one byte. The character value is the byte's low `char_bits` bits, zero-extended. The count equals the number of characters, and the start address may be odd.
- R6: When `char_bits` is more than 8, each character is two bytes. The byte at address a goes to bits 15..8 and the byte at a+1 goes to bits 7..0. The character is the low `char_bits` bits of this 16-bit value, and the count is twice the number of characters.
- R7: A start is refused if the count is 0, or if `char_bits` is more than 8 and either the count or the address is odd. A refused start gives a one-cycle `err` pulse, issues no memory read and sends no character.
- R8: While `tx_valid` is high and `tx_ready` is low, `tx_valid` stays high and `tx_data` holds its value.
- R9: In slave mode, a start is taken while the block is idle, whatever the value of `bd_ready`. The first character is fetched at once. It is not offered on the stream until a cycle in which `slv_select` and `slv_sck_edge` are both high.
- R10: `done` pulses for one cycle, in the cycle after the last character is handed over. After that the block is idle and takes a new start.
- R11: The count, address, width and role are captured when the start is taken. Changing these inputs during the transfer has no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_we | input | 1 | Write strobe for the command byte |
| cmd_wdata | input | 8 | Command write data; bit 0 is the start bit |
| cmd_rdata | output | 8 | Command read data |
| bd_len | input | LEN_W | Descriptor byte count |
| bd_ptr | input | ADDR_W | Descriptor buffer start address |
| bd_ready | input | 1 | Descriptor ready flag |
| char_bits | input | 5 | Character width, 4 to 16 |
| slave_mode | input | 1 | 1 selects slave role, 0 selects master role |
| slv_select | input | 1 | External select is active (slave role) |
| slv_sck_edge | input | 1 | Single-cycle strobe marking a serial clock edge (slave role) |
| mem_rd_en | output | 1 | Buffer memory read request |
| mem_addr | output | ADDR_W | Buffer memory byte address |
| mem_rdata | input | 8 | Read data, valid in the cycle after the request |
| tx_valid | output | 1 | A character is offered |
| tx_ready | input | 1 | The shifter takes the character |
| tx_data | output | 16 | Character, right-aligned |
| done | output | 1 | One-cycle pulse when the buffer is finished |
| err | output | 1 | One-cycle pulse when a descriptor is refused |

## Verification
The bench builds the block with an 8-bit address and an 8-bit count, so a 256-byte model memory covers every address. This makes it possible to test odd start addresses and buffers near the top of memory. The tests cover character widths of 4, 5, 8, 12 and 16, so both the masking of narrow characters and the big-endian packing of half-words are checked. A repeating back-pressure pattern on `tx_ready` holds characters across several cycles.

// File: rtl/spitx_pkg.sv
package spitx_pkg;
  localparam int CHAR_MAX = 16;
  localparam int CW_W     = 5;
  localparam int CMD_W    = 8;
  localparam int START_BIT = 0;

  typedef enum logic [1:0] {
    F_IDLE  = 2'd0,
    F_ISSUE = 2'd1,
    F_CAPT  = 2'd2,
    F_WAIT  = 2'd3
  } fstate_t;
endpackage

// File: rtl/spitx_cmd.sv
module spitx_cmd
  import spitx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [CMD_W-1:0] wdata,
  output logic [CMD_W-1:0] rdata,
  output logic             start_o
);
  logic start_q;

  // The start bit is set by a write and drops again one clock later.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) start_q <= 1'b0;
    else        start_q <= we & wdata[START_BIT];
  end

  always_comb begin
    rdata = '0;
    rdata[START_BIT] = start_q;
  end
  assign start_o = start_q;

  assert_start_selfclear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start_q && !(we && wdata[START_BIT])) |=> !start_q);
endmodule

// File: rtl/spitx_fetch.sv
module spitx_fetch
  import spitx_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int LEN_W  = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [LEN_W-1:0]    bd_len,
  input  logic [ADDR_W-1:0]   bd_ptr,
  input  logic                bd_ready,
  input  logic [CW_W-1:0]     char_bits,
  input  logic                slave_mode,
  input  logic                pop,
  output logic                mem_rd_en,
  output logic [ADDR_W-1:0]   mem_addr,
  input  logic [7:0]          mem_rdata,
  output logic                load,
  output logic [CHAR_MAX-1:0] load_data,
  output logic                done,
  output logic                err,
  output logic                busy,
  output logic                slave_q
);
  fstate_t             st;
  logic [ADDR_W-1:0]   ptr_q;
  logic [LEN_W-1:0]    rem_q;
  logic [CW_W-1:0]     cw_q;
  logic                wide_q;
  logic                lo_next_q;
  logic [7:0]          hi_q;
  logic                done_q, err_q;

  logic                accept, bad, wide_in;
  logic [CHAR_MAX:0]   one_sh;
  logic [CHAR_MAX-1:0] mask, raw;
  logic [LEN_W-1:0]    step, rem_next;

  assign wide_in = (char_bits > CW_W'(8));
  assign accept  = start && (st == F_IDLE) && (slave_mode || bd_ready);
  assign bad     = (bd_len == '0) || (wide_in && (bd_len[0] || bd_ptr[0]));

  // Character mask: the low cw_q bits are kept.
  assign one_sh = {{CHAR_MAX{1'b0}}, 1'b1} << cw_q;
  assign mask   = one_sh[CHAR_MAX-1:0] - CHAR_MAX'(1);

  // Wide characters are big-endian: the byte read first goes to the upper half.
  always_comb begin
    if (wide_q) raw = {hi_q, mem_rdata};
    else        raw = {{(CHAR_MAX-8){1'b0}}, mem_rdata};
  end

  assign step     = wide_q ? LEN_W'(2) : LEN_W'(1);
  assign rem_next = rem_q - step;

  assign mem_rd_en = (st == F_ISSUE);
  assign mem_addr  = ptr_q;
  assign load      = (st == F_CAPT) && !(wide_q && !lo_next_q);
  assign load_data = raw & mask;
  assign done      = done_q;
  assign err       = err_q;
  assign busy      = (st != F_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= F_IDLE;
      ptr_q     <= '0;
      rem_q     <= '0;
      cw_q      <= CW_W'(8);
      wide_q    <= 1'b0;
      lo_next_q <= 1'b0;
      hi_q      <= '0;
      done_q    <= 1'b0;
      err_q     <= 1'b0;
      slave_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      case (st)
        F_IDLE: begin
          if (accept) begin
            if (bad) begin
              err_q <= 1'b1;
            end else begin
              ptr_q     <= bd_ptr;
              rem_q     <= bd_len;
              cw_q      <= char_bits;
              wide_q    <= wide_in;
              slave_q   <= slave_mode;
              lo_next_q <= 1'b0;
              st        <= F_ISSUE;
            end
          end
        end
        F_ISSUE: begin
          ptr_q <= ptr_q + ADDR_W'(1);
          st    <= F_CAPT;
        end
        F_CAPT: begin
          if (wide_q && !lo_next_q) begin
            hi_q      <= mem_rdata;
            lo_next_q <= 1'b1;
            st        <= F_ISSUE;
          end else begin
            lo_next_q <= 1'b0;
            st        <= F_WAIT;
          end
        end
        F_WAIT: begin
          if (pop) begin
            rem_q <= rem_next;
            if (rem_next == '0) begin
              done_q <= 1'b1;
              st     <= F_IDLE;
            end else begin
              st <= F_ISSUE;
            end
          end
        end
        default: st <= F_IDLE;
      endcase
    end
  end

  assert_err_no_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> (!mem_rd_en && !load));
  assert_wide_even_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_en && wide_q && !lo_next_q) |-> !mem_addr[0]);
  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
  assert_busy_ignores_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> !err_q);
endmodule

// File: rtl/spitx_hold.sv
module spitx_hold
  import spitx_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic [CHAR_MAX-1:0] load_data,
  input  logic                busy,
  input  logic                slave_q,
  input  logic                sel,
  input  logic                sck_edge,
  input  logic                tx_ready,
  output logic                tx_valid,
  output logic [CHAR_MAX-1:0] tx_data,
  output logic                pop
);
  logic                full_q, rel_q;
  logic [CHAR_MAX-1:0] data_q;

  assign tx_valid = full_q && (!slave_q || rel_q);
  assign tx_data  = data_q;
  assign pop      = tx_valid && tx_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      data_q <= '0;
      rel_q  <= 1'b0;
    end else begin
      if (load) begin
        full_q <= 1'b1;
        data_q <= load_data;
      end else if (pop) begin
        full_q <= 1'b0;
      end
      // The slave release gate opens once per transfer.
      if (!busy)                          rel_q <= 1'b0;
      else if (slave_q && sel && sck_edge) rel_q <= 1'b1;
    end
  end

  assert_hold_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));
  assert_slave_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (slave_q && !rel_q) |-> !tx_valid);
endmodule

// File: rtl/spi_txbuf_fetch.sv
module spi_txbuf_fetch
  import spitx_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_we,
  input  logic [7:0]        cmd_wdata,
  output logic [7:0]        cmd_rdata,
  input  logic [LEN_W-1:0]  bd_len,
  input  logic [ADDR_W-1:0] bd_ptr,
  input  logic              bd_ready,
  input  logic [4:0]        char_bits,
  input  logic              slave_mode,
  input  logic              slv_select,
  input  logic              slv_sck_edge,
  output logic              mem_rd_en,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [7:0]        mem_rdata,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [15:0]       tx_data,
  output logic              done,
  output logic              err
);
  logic                start, pop, load, busy, slave_q;
  logic [CHAR_MAX-1:0] load_data;

  spitx_cmd u_cmd (
    .clk(clk), .rst_n(rst_n), .we(cmd_we), .wdata(cmd_wdata),
    .rdata(cmd_rdata), .start_o(start)
  );

  spitx_fetch #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_fetch (
    .clk(clk), .rst_n(rst_n), .start(start), .bd_len(bd_len), .bd_ptr(bd_ptr),
    .bd_ready(bd_ready), .char_bits(char_bits), .slave_mode(slave_mode),
    .pop(pop), .mem_rd_en(mem_rd_en), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .load(load), .load_data(load_data), .done(done), .err(err),
    .busy(busy), .slave_q(slave_q)
  );

  spitx_hold u_hold (
    .clk(clk), .rst_n(rst_n), .load(load), .load_data(load_data), .busy(busy),
    .slave_q(slave_q), .sel(slv_select), .sck_edge(slv_sck_edge),
    .tx_ready(tx_ready), .tx_valid(tx_valid), .tx_data(tx_data), .pop(pop)
  );

  assert_done_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !tx_valid);
  assert_err_not_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !tx_valid);
endmodule

// File: tb/sim_spi_txbuf_fetch.sv
module sim_spi_txbuf_fetch;
  localparam int PERIOD = 10;
  localparam int AW = 8;
  localparam int LW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_we = 1'b0;
  logic [7:0] cmd_wdata = '0;
  logic [7:0] cmd_rdata;
  logic [LW-1:0] bd_len = '0;
  logic [AW-1:0] bd_ptr = '0;
  logic bd_ready = 1'b0;
  logic [4:0] char_bits = 5'd8;
  logic slave_mode = 1'b0;
  logic slv_select = 1'b0;
  logic slv_sck_edge = 1'b0;
  logic mem_rd_en;
  logic [AW-1:0] mem_addr;
  logic [7:0] mem_rdata = '0;
  logic tx_valid;
  logic tx_ready = 1'b1;
  logic [15:0] tx_data;
  logic done, err;

  int checks = 0, errors = 0;
  int done_cnt = 0, err_cnt = 0, rd_cnt = 0, item_cnt = 0;
  logic bp_on = 1'b0;
  int bp_cnt = 0;
  logic [7:0] mem [256];
  logic [15:0] exp_q [$];

  always #(PERIOD/2) clk = ~clk;

  spi_txbuf_fetch #(.ADDR_W(AW), .LEN_W(LW)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_wdata(cmd_wdata),
    .cmd_rdata(cmd_rdata), .bd_len(bd_len), .bd_ptr(bd_ptr), .bd_ready(bd_ready),
    .char_bits(char_bits), .slave_mode(slave_mode), .slv_select(slv_select),
    .slv_sck_edge(slv_sck_edge), .mem_rd_en(mem_rd_en), .mem_addr(mem_addr),
    .mem_rdata(mem_rdata), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_data(tx_data), .done(done), .err(err)
  );

  // Buffer memory model with one cycle of read latency.
  always @(posedge clk) if (mem_rd_en) mem_rdata <= mem[mem_addr];

  // Back-pressure pattern, changed just after each rising edge.
  always @(posedge clk) begin
    #1;
    bp_cnt++;
    tx_ready = bp_on ? ((bp_cnt % 3) != 0) : 1'b1;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Monitor: every handshake pops the scoreboard.
  always @(negedge clk) if (rst_n) begin
    if (done) done_cnt++;
    if (err) err_cnt++;
    if (mem_rd_en) rd_cnt++;
    if (tx_valid && tx_ready) begin
      item_cnt++;
      if (exp_q.size() == 0) begin
        check(1'b0, "R3/R4 unexpected character", int'(tx_data), 0);
      end else begin
        logic [15:0] e;
        e = exp_q.pop_front();
        check(tx_data == e, "R5/R6 character value", int'(tx_data), int'(e));
      end
    end
  end

  function automatic logic [15:0] exp_char(int p, bit wide, int cw);
    logic [15:0] v, m;
    m = 16'((32'd1 << cw) - 1);
    v = wide ? {mem[p & 255], mem[(p + 1) & 255]} : {8'h00, mem[p & 255]};
    return v & m;
  endfunction

  task automatic push_expected(int len, int ptr, int cw);
    bit wide;
    wide = cw > 8;
    for (int i = 0; i < len; i += (wide ? 2 : 1))
      exp_q.push_back(exp_char(ptr + i, wide, cw));
  endtask

  task automatic wr_cmd(input logic [7:0] d);
    @(posedge clk); #1;
    cmd_we = 1'b1; cmd_wdata = d;
    @(posedge clk); #1;
    cmd_we = 1'b0; cmd_wdata = '0;
  endtask

  task automatic set_bd(int len, int ptr, int cw, bit slv, bit rdy);
    @(posedge clk); #1;
    bd_len = LW'(len); bd_ptr = AW'(ptr); char_bits = 5'(cw);
    slave_mode = slv; bd_ready = rdy;
  endtask

  task automatic wait_done(input string req, input int d0, input int n_exp);
    int t;
    t = 0;
    while (done_cnt == d0 && t < 600) begin @(negedge clk); t++; end
    check(done_cnt == d0 + 1, req, done_cnt - d0, 1);
    check(exp_q.size() == 0, req, exp_q.size(), 0);
    @(negedge clk);
    check(!tx_valid, req, int'(tx_valid), 0);
    if (n_exp < 0) ;
  endtask

  task automatic run_master(int len, int ptr, int cw, string req);
    int d0;
    set_bd(len, ptr, cw, 1'b0, 1'b1);
    push_expected(len, ptr, cw);
    d0 = done_cnt;
    wr_cmd(8'h01);
    wait_done(req, d0, 0);
  endtask

  task automatic expect_refusal(int len, int ptr, int cw, string req);
    int e0, r0, i0;
    set_bd(len, ptr, cw, 1'b0, 1'b1);
    e0 = err_cnt; r0 = rd_cnt; i0 = item_cnt;
    wr_cmd(8'h01);
    repeat (10) @(negedge clk);
    check(err_cnt == e0 + 1, req, err_cnt - e0, 1);
    check(rd_cnt == r0, req, rd_cnt - r0, 0);
    check(item_cnt == i0, req, item_cnt - i0, 0);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'((i * 37 + 11) & 255);
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R2: reset state
    check(cmd_rdata == 8'h00, "R2 reset value", int'(cmd_rdata), 0);
    check(!tx_valid && !done && !err, "R2 reset outputs", int'({tx_valid, done, err}), 0);

    // R1/R2/R3: write all ones with ready low in master role
    set_bd(4, 8, 8, 1'b0, 1'b0);
    @(posedge clk); #1;
    cmd_we = 1'b1; cmd_wdata = 8'hFF;
    @(posedge clk); #1;
    cmd_we = 1'b0; cmd_wdata = '0;
    check(cmd_rdata == 8'h01, "R1 reserved bits read 0, R2 start reads 1", int'(cmd_rdata), 1);
    @(posedge clk); #1;
    check(cmd_rdata == 8'h00, "R2 start clears itself", int'(cmd_rdata), 0);
    repeat (10) @(negedge clk);
    check(rd_cnt == 0 && item_cnt == 0, "R3 start without ready dropped", rd_cnt + item_cnt, 0);
    // R3: raising ready afterwards must not revive the dropped start
    set_bd(4, 8, 8, 1'b0, 1'b1);
    repeat (10) @(negedge clk);
    check(rd_cnt == 0, "R3 no queued start", rd_cnt, 0);

    // R5: narrow characters, odd start address
    run_master(5, 8'h13, 8, "R5 byte chars odd address");
    // R5 + R8: masked 5-bit characters under back-pressure
    bp_on = 1'b1;
    run_master(3, 8'h40, 5, "R5/R8 masked under back-pressure");
    run_master(4, 8'hFC, 4, "R5 4-bit chars at top of memory");
    // R6: wide characters
    run_master(6, 8'h20, 12, "R6 12-bit half-words");
    run_master(4, 8'h7E, 16, "R6 16-bit half-words");
    bp_on = 1'b0;

    // R7: refused descriptors
    expect_refusal(0, 8'h10, 8, "R7 zero length");
    expect_refusal(5, 8'h10, 9, "R7 odd length wide");
    expect_refusal(4, 8'h11, 16, "R7 odd pointer wide");

    // R4 + R11: restart and descriptor changes during a transfer
    begin
      int d0;
      bp_on = 1'b1;
      set_bd(8, 8'h50, 10, 1'b0, 1'b1);
      push_expected(8, 8'h50, 10);
      d0 = done_cnt;
      wr_cmd(8'h01);
      repeat (3) @(negedge clk);
      set_bd(2, 8'h91, 6, 1'b1, 1'b0);
      wr_cmd(8'h01);
      wait_done("R4/R11 busy start and live inputs ignored", d0, 0);
      repeat (30) @(negedge clk);
      check(done_cnt == d0 + 1, "R4 no second transfer", done_cnt - d0, 1);
      bp_on = 1'b0;
    end

    // R9: slave start without ready, held until select and edge
    begin
      int d0;
      set_bd(3, 8'h31, 8, 1'b1, 1'b0);
      push_expected(3, 8'h31, 8);
      d0 = done_cnt;
      wr_cmd(8'h01);
      repeat (20) @(negedge clk);
      check(rd_cnt > 0, "R9 first character fetched", rd_cnt, 1);
      check(!tx_valid, "R9 held until select and edge", int'(tx_valid), 0);
      @(posedge clk); #1 slv_select = 1'b1;
      repeat (3) @(negedge clk);
      check(!tx_valid, "R9 select alone does not release", int'(tx_valid), 0);
      @(posedge clk); #1 slv_sck_edge = 1'b1;
      @(posedge clk); #1 slv_sck_edge = 1'b0;
      wait_done("R9/R10 slave transfer", d0, 0);
      slv_select = 1'b0;
    end

    // R10: back to idle, a new master transfer is taken at once
    run_master(2, 8'h05, 7, "R10 idle after done");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule